// File: doc/BRIEF.md
# Latency-Ordered Result Commit Buffer

This block sits beside one functional unit of a statically scheduled wide-issue core. Each operation on that unit carries a latency that the compiler assumed. Its result must reach the architectural register file no sooner than that many instructions after issue. The hardware may finish earlier or later than the compiler assumed, and the buffer hides that difference.

The buffer is a ring of elements with a commit pointer. The pointer steps forward by one element for every issued instruction. When an operation issues, it claims the element that lies latency minus one positions ahead of the pointer. The unit later returns its result tagged with that element index.

A result that comes back before the pointer reaches its element is parked in the element. It is written to the register file only when the pointer arrives. A result that is still missing when the pointer arrives marks the element overdue. That result is then written in the same cycle it comes back. The issue logic is told to stall when the claimed element cannot be taken.

Top module: `delayed_wb_buffer`

## Requirements
- R1: The commit pointer advances by exactly one element on each issue step (`adv_i` high and `stall_o` low), wrapping from DEPTH-1 to 0. It does not move in any other cycle.
- R2: An accepted allocation takes element (pointer + latency - 1) mod DEPTH, and `alloc_idx_o` shows that index in the same cycle.
- R3: A result that arrives before the pointer reaches its element produces no register write on arrival. It is written, with the allocation's destination register, in the issue step in which the pointer stands on that element.
- R4: When the pointer passes an element whose result is still missing, nothing is written at that step. The result is written in the very cycle it later arrives on the completion port.
- R5: A latency of 1 claims the element under the pointer and makes it overdue in that same issue step, so its result is written on arrival.
- R6: A result that arrives in the same cycle as the issue step that reaches its element is written in that cycle.
- R7: An allocation with latency 0, or with latency greater than DEPTH, raises `stall_o` when `adv_i` is high.
- R8: `stall_o` is raised while the claimed element still waits for its result, is overdue, or holds a parked result that is not under the pointer. A parked result under the pointer is written out in that step, and the element is reused.
- R9: If an overdue write and a parked release fall in the same cycle, the overdue write goes out first and the parked one goes out in the next cycle. During that next cycle `stall_o` is high whenever `adv_i` is high.
- R10: After reset there are no writes, no stall, and the pointer is at element 0.
- R11: Once an overdue result has been written, its element can be claimed again without a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| adv_i | input | 1 | An instruction is being issued this cycle |
| alloc_v_i | input | 1 | The instruction carries an operation for this unit |
| alloc_reg_i | input | REG_AW | Destination architectural register |
| alloc_lat_i | input | $clog2(DEPTH)+2 | Assumed latency in instructions |
| alloc_idx_o | output | $clog2(DEPTH) | Element claimed by the allocation |
| stall_o | output | 1 | Issue must hold this cycle |
| cmpl_v_i | input | 1 | A result is returned |
| cmpl_idx_i | input | $clog2(DEPTH) | Element the result belongs to |
| cmpl_data_i | input | DATA_W | Result value |
| wr_en_o | output | 1 | Register file write enable |
| wr_reg_o | output | REG_AW | Register file write address |
| wr_data_o | output | DATA_W | Register file write data |

## Verification
Some internal faults show at the ports at once. A pointer that drifts by one moves every following `alloc_idx_o` and shifts each parked release by a cycle. A wrong element state can release a parked result on arrival instead of at the pointer's step. It can also hold an overdue result back, or raise a spurious `stall_o` on the next allocation that hits that element. A lost holding register drops or duplicates a register write in the cycle after a collision. The bench keeps an in-order queue of expected writes and checks, for every cycle, whether a write was due. Any of these faults therefore shows up within the cycle it takes effect, or at the latest in the next cycle that touches the damaged element.

// File: rtl/dwb_pkg.sv
package dwb_pkg;
  // Element life cycle. Invalid = WAIT or LATE, copyback = LATE.
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,  // free
    SLOT_WAIT = 2'd1,  // claimed, result outstanding, pointer not yet there
    SLOT_HELD = 2'd2,  // result parked, waiting for the pointer
    SLOT_LATE = 2'd3   // pointer passed, result still outstanding
  } slot_st_e;
endpackage

// File: rtl/dwb_ptr.sv
module dwb_ptr #(
  parameter int DEPTH = 8,
  parameter int LAT_W = 5,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic [IDX_W-1:0] ptr_o,
  output logic [IDX_W-1:0] tgt_o,
  output logic             lat_ok_o
);
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [IDX_W-1:0] lat_m1;
  logic [IDX_W:0]   sum;

  assign lat_ok_o = (lat_i != '0) && (lat_i <= LAT_W'(DEPTH));
  assign lat_m1   = IDX_W'(lat_i - LAT_W'(1));
  assign sum      = {1'b0, ptr_q} + {1'b0, lat_m1};
  assign tgt_o    = (sum >= (IDX_W+1)'(DEPTH)) ? IDX_W'(sum - (IDX_W+1)'(DEPTH))
                                               : IDX_W'(sum);
  assign ptr_o    = ptr_q;

  always_comb begin
    ptr_d = (ptr_q == IDX_W'(DEPTH-1)) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (step_i) ptr_q <= ptr_d;
  end

  assert_ptr_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(ptr_q));
  assert_ptr_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && ptr_q == IDX_W'(DEPTH-1)) |=> (ptr_q == '0));
endmodule

// File: rtl/dwb_slots.sv
module dwb_slots import dwb_pkg::*; #(
  parameter int DEPTH  = 8,
  parameter int REG_AW = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [IDX_W-1:0]  ptr_i,
  input  logic              alloc_i,
  input  logic [IDX_W-1:0]  tgt_i,
  input  logic [REG_AW-1:0] areg_i,
  input  logic              cmpl_v_i,
  input  logic [IDX_W-1:0]  cmpl_idx_i,
  input  logic [DATA_W-1:0] cmpl_data_i,
  output logic              busy_o,
  output logic              late_v_o,
  output logic [REG_AW-1:0] late_reg_o,
  output logic [DATA_W-1:0] late_data_o,
  output logic              rel_v_o,
  output logic [REG_AW-1:0] rel_reg_o,
  output logic [DATA_W-1:0] rel_data_o
);
  slot_st_e          st_q [DEPTH];
  slot_st_e          st_d [DEPTH];
  logic [REG_AW-1:0] reg_q [DEPTH];
  logic [DATA_W-1:0] dat_q [DEPTH];
  logic [DEPTH-1:0]  inv_v, cb_v, held_v;

  for (genvar g = 0; g < DEPTH; g++) begin : g_flag
    assign inv_v[g]  = (st_q[g] == SLOT_WAIT) || (st_q[g] == SLOT_LATE);
    assign cb_v[g]   = (st_q[g] == SLOT_LATE);
    assign held_v[g] = (st_q[g] == SLOT_HELD);
  end

  // Result arriving for an overdue element, or exactly as the pointer reaches it.
  assign late_v_o    = cmpl_v_i && (cb_v[cmpl_idx_i] ||
                       (step_i && (cmpl_idx_i == ptr_i) && inv_v[cmpl_idx_i]));
  assign late_reg_o  = reg_q[cmpl_idx_i];
  assign late_data_o = cmpl_data_i;

  // Parked result released by the pointer.
  assign rel_v_o    = step_i && held_v[ptr_i];
  assign rel_reg_o  = reg_q[ptr_i];
  assign rel_data_o = dat_q[ptr_i];

  assign busy_o = inv_v[tgt_i] || (held_v[tgt_i] && (tgt_i != ptr_i));

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      st_d[i] = st_q[i];
      if (step_i && ptr_i == IDX_W'(i)) begin
        if (st_q[i] == SLOT_HELD)      st_d[i] = SLOT_IDLE;
        else if (st_q[i] == SLOT_WAIT) st_d[i] = SLOT_LATE;
      end
      if (cmpl_v_i && cmpl_idx_i == IDX_W'(i)) begin
        if (st_q[i] == SLOT_LATE ||
            (st_q[i] == SLOT_WAIT && step_i && ptr_i == IDX_W'(i)))
          st_d[i] = SLOT_IDLE;
        else if (st_q[i] == SLOT_WAIT)
          st_d[i] = SLOT_HELD;
      end
      if (alloc_i && tgt_i == IDX_W'(i))
        st_d[i] = (tgt_i == ptr_i) ? SLOT_LATE : SLOT_WAIT;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) st_q[i] <= SLOT_IDLE;
    end else begin
      for (int i = 0; i < DEPTH; i++) st_q[i] <= st_d[i];
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (alloc_i && tgt_i == IDX_W'(i)) reg_q[i] <= areg_i;
      if (cmpl_v_i && cmpl_idx_i == IDX_W'(i) && st_q[i] == SLOT_WAIT)
        dat_q[i] <= cmpl_data_i;
    end
  end

  assert_alloc_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |=> inv_v[$past(tgt_i)]);
  assert_late_frees_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_v_o |=> !inv_v[$past(cmpl_idx_i)]);
endmodule

// File: rtl/dwb_wport.sv
module dwb_wport #(
  parameter int REG_AW = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              late_v_i,
  input  logic [REG_AW-1:0] late_reg_i,
  input  logic [DATA_W-1:0] late_data_i,
  input  logic              rel_v_i,
  input  logic [REG_AW-1:0] rel_reg_i,
  input  logic [DATA_W-1:0] rel_data_i,
  output logic              hold_o,
  output logic              wr_en_o,
  output logic [REG_AW-1:0] wr_reg_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic              hold_q, hold_d, hload;
  logic [REG_AW-1:0] hreg_q;
  logic [DATA_W-1:0] hdat_q;

  always_comb begin
    wr_en_o   = 1'b0;
    wr_reg_o  = late_reg_i;
    wr_data_o = late_data_i;
    hold_d    = hold_q;
    hload     = 1'b0;
    if (late_v_i) begin
      wr_en_o = 1'b1;
      if (rel_v_i) begin
        hload  = 1'b1;
        hold_d = 1'b1;
      end
    end else if (hold_q) begin
      wr_en_o   = 1'b1;
      wr_reg_o  = hreg_q;
      wr_data_o = hdat_q;
      hold_d    = 1'b0;
    end else if (rel_v_i) begin
      wr_en_o   = 1'b1;
      wr_reg_o  = rel_reg_i;
      wr_data_o = rel_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b0;
    else         hold_q <= hold_d;
  end

  always_ff @(posedge clk_i) begin
    if (hload) begin
      hreg_q <= rel_reg_i;
      hdat_q <= rel_data_i;
    end
  end

  assign hold_o = hold_q;

  assert_no_overrun_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q |-> !rel_v_i);
  assert_hold_drain_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && !late_v_i) |=> !hold_q);
endmodule

// File: rtl/delayed_wb_buffer.sv
module delayed_wb_buffer #(
  parameter int DEPTH  = 8,
  parameter int REG_AW = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LAT_W = $clog2(DEPTH) + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              alloc_v_i,
  input  logic [REG_AW-1:0] alloc_reg_i,
  input  logic [LAT_W-1:0]  alloc_lat_i,
  output logic [IDX_W-1:0]  alloc_idx_o,
  output logic              stall_o,
  input  logic              cmpl_v_i,
  input  logic [IDX_W-1:0]  cmpl_idx_i,
  input  logic [DATA_W-1:0] cmpl_data_i,
  output logic              wr_en_o,
  output logic [REG_AW-1:0] wr_reg_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic              step, alloc_fire, lat_ok, busy, hold;
  logic [IDX_W-1:0]  ptr, tgt;
  logic              late_v, rel_v;
  logic [REG_AW-1:0] late_reg, rel_reg;
  logic [DATA_W-1:0] late_data, rel_data;

  assign stall_o     = adv_i && (hold || (alloc_v_i && (!lat_ok || busy)));
  assign step        = adv_i && !stall_o;
  assign alloc_fire  = step && alloc_v_i;
  assign alloc_idx_o = tgt;

  dwb_ptr #(.DEPTH(DEPTH), .LAT_W(LAT_W)) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step), .lat_i(alloc_lat_i),
    .ptr_o(ptr), .tgt_o(tgt), .lat_ok_o(lat_ok)
  );

  dwb_slots #(.DEPTH(DEPTH), .REG_AW(REG_AW), .DATA_W(DATA_W)) u_slots (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step), .ptr_i(ptr),
    .alloc_i(alloc_fire), .tgt_i(tgt), .areg_i(alloc_reg_i),
    .cmpl_v_i(cmpl_v_i), .cmpl_idx_i(cmpl_idx_i), .cmpl_data_i(cmpl_data_i),
    .busy_o(busy), .late_v_o(late_v), .late_reg_o(late_reg), .late_data_o(late_data),
    .rel_v_o(rel_v), .rel_reg_o(rel_reg), .rel_data_o(rel_data)
  );

  dwb_wport #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_wport (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .late_v_i(late_v), .late_reg_i(late_reg), .late_data_i(late_data),
    .rel_v_i(rel_v), .rel_reg_i(rel_reg), .rel_data_i(rel_data),
    .hold_o(hold), .wr_en_o(wr_en_o), .wr_reg_o(wr_reg_o), .wr_data_o(wr_data_o)
  );

  assert_late_same_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_v |-> (wr_en_o && wr_data_o == cmpl_data_i));
  assert_stall_blocks_alloc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && alloc_v_i && !lat_ok) |-> stall_o);
endmodule

// File: tb/delayed_wb_buffer_tb.sv
module delayed_wb_buffer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv, av, cv;
  logic [4:0]  areg, alat;
  logic [2:0]  cidx;
  logic [31:0] cdata;
  logic [2:0]  alloc_idx_o;
  logic        stall_o, wr_en_o;
  logic [4:0]  wr_reg_o;
  logic [31:0] wr_data_o;

  int vecs = 0;
  int errs = 0;
  logic [36:0] expq [$];
  string       tagq [$];

  always #2ns clk = ~clk;

  delayed_wb_buffer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .adv_i(adv), .alloc_v_i(av),
    .alloc_reg_i(areg), .alloc_lat_i(alat), .alloc_idx_o(alloc_idx_o),
    .stall_o(stall_o), .cmpl_v_i(cv), .cmpl_idx_i(cidx), .cmpl_data_i(cdata),
    .wr_en_o(wr_en_o), .wr_reg_o(wr_reg_o), .wr_data_o(wr_data_o)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected writes in order as the design emits them.
  always @(negedge clk) begin
    #1ns;
    if (rst_n && wr_en_o) begin
      if (expq.size() == 0) begin
        chk("R3 unexpected register write", {27'd0, wr_reg_o, wr_data_o}, 64'd0);
      end else begin
        logic [36:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk({t, " write content"}, {27'd0, wr_reg_o, wr_data_o}, {27'd0, e});
      end
    end
  end

  // Driver: one cycle of stimulus plus the expectations for that cycle.
  task automatic cyc(bit a, bit v, logic [4:0] r, logic [4:0] l,
                     bit c, logic [2:0] ci, logic [31:0] cd,
                     bit xs, bit xw, logic [4:0] xr, logic [31:0] xd,
                     int xi, string tag);
    @(negedge clk);
    adv = a; av = v; areg = r; alat = l; cv = c; cidx = ci; cdata = cd;
    if (xw) begin
      expq.push_back({xr, xd});
      tagq.push_back(tag);
    end
    #1ns;
    chk({tag, " stall"}, {63'd0, stall_o}, {63'd0, xs});
    chk({tag, " write strobe"}, {63'd0, wr_en_o}, {63'd0, xw});
    if (xi >= 0) chk({tag, " alloc index"}, {61'd0, alloc_idx_o}, 64'(xi));
  endtask

  initial begin
    #800us;
    errs++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    adv = 0; av = 0; areg = 0; alat = 0; cv = 0; cidx = 0; cdata = 0;
    repeat (3) @(negedge clk);
    #1ns;
    chk("R10 reset write strobe", {63'd0, wr_en_o}, 64'd0);
    chk("R10 reset stall", {63'd0, stall_o}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(0,0,0,0, 0,0,0, 0,0,0,0, -1, "R10 idle");
    // Latency 1 at pointer 0: element 0, overdue at once, written on arrival.
    cyc(1,1,5'd1,5'd1, 0,0,0, 0,0,0,0, 0, "R5 lat1 alloc");
    cyc(0,0,0,0, 1,3'd0,32'h100, 0,1,5'd1,32'h100, -1, "R5 lat1 result");
    // Early result: pointer 1, latency 4 -> element 4.
    cyc(1,1,5'd3,5'd4, 0,0,0, 0,0,0,0, 4, "R2 early alloc");
    cyc(0,0,0,0, 1,3'd4,32'h300, 0,0,0,0, -1, "R3 early arrival held");
    cyc(1,0,0,0, 0,0,0, 0,0,0,0, -1, "R3 pointer at 2");
    cyc(1,0,0,0, 0,0,0, 0,0,0,0, -1, "R3 pointer at 3");
    cyc(1,0,0,0, 0,0,0, 0,1,5'd3,32'h300, -1, "R3 pointer reaches 4");
    // Late result: pointer 5, latency 2 -> element 6.
    cyc(1,1,5'd7,5'd2, 0,0,0, 0,0,0,0, 6, "R4 late alloc");
    cyc(1,0,0,0, 0,0,0, 0,0,0,0, -1, "R4 pointer passes 6");
    cyc(0,0,0,0, 0,0,0, 0,0,0,0, -1, "R4 still missing");
    cyc(0,0,0,0, 0,0,0, 0,0,0,0, -1, "R4 still missing");
    cyc(0,0,0,0, 1,3'd6,32'h700, 0,1,5'd7,32'h700, -1, "R4 late arrival");
    // On time: pointer 7, latency 2 wraps to element 0.
    cyc(1,1,5'd9,5'd2, 0,0,0, 0,0,0,0, 0, "R2 wrap alloc");
    cyc(1,0,0,0, 1,3'd0,32'h900, 0,1,5'd9,32'h900, -1, "R6 on-time arrival");
    // Latency out of range, pointer 1 must not move.
    cyc(1,1,5'd11,5'd9, 0,0,0, 1,0,0,0, -1, "R7 latency above depth");
    cyc(1,1,5'd11,5'd0, 0,0,0, 1,0,0,0, -1, "R7 latency zero");
    cyc(1,1,5'd11,5'd1, 0,0,0, 0,0,0,0, 1, "R1 pointer held by stall");
    cyc(0,0,0,0, 1,3'd1,32'hB00, 0,1,5'd11,32'hB00, -1, "R5 lat1 result");
    // Busy target: pointer 2, latency 3 -> element 4.
    cyc(1,1,5'd12,5'd3, 0,0,0, 0,0,0,0, 4, "R8 first claim");
    cyc(1,1,5'd13,5'd2, 0,0,0, 1,0,0,0, -1, "R8 target waiting");
    cyc(0,0,0,0, 1,3'd4,32'hC00, 0,0,0,0, -1, "R3 parked in 4");
    cyc(1,1,5'd13,5'd2, 0,0,0, 1,0,0,0, -1, "R8 target parked ahead");
    cyc(1,0,0,0, 0,0,0, 0,0,0,0, -1, "R1 step to 4");
    cyc(1,1,5'd13,5'd1, 0,0,0, 0,1,5'd12,32'hC00, 4, "R8 release and reuse");
    cyc(0,0,0,0, 1,3'd4,32'hD00, 0,1,5'd13,32'hD00, -1, "R11 reused element result");
    // Collision: pointer 5.
    cyc(1,1,5'd14,5'd1, 0,0,0, 0,0,0,0, 5, "R9 overdue claim");
    cyc(1,1,5'd15,5'd2, 0,0,0, 0,0,0,0, 7, "R9 parked claim");
    cyc(0,0,0,0, 1,3'd7,32'hF00, 0,0,0,0, -1, "R3 parked in 7");
    cyc(1,0,0,0, 1,3'd5,32'hE00, 0,1,5'd14,32'hE00, -1, "R9 overdue wins");
    cyc(1,0,0,0, 0,0,0, 1,1,5'd15,32'hF00, -1, "R9 held release");
    cyc(1,1,5'd16,5'd1, 0,0,0, 0,0,0,0, 0, "R9 pointer held during drain");
    cyc(0,0,0,0, 1,3'd0,32'h1000, 0,1,5'd16,32'h1000, -1, "R11 element 0 result");
    // Full-depth latency from pointer 1 -> element 0.
    cyc(1,1,5'd17,5'd8, 0,0,0, 0,0,0,0, 0, "R2 max latency");
    for (int k = 0; k < 6; k++)
      cyc(1,0,0,0, 0,0,0, 0,0,0,0, -1, "R1 lap");
    cyc(1,0,0,0, 0,0,0, 0,0,0,0, -1, "R4 pointer passes 0");
    cyc(0,0,0,0, 1,3'd0,32'h1700, 0,1,5'd17,32'h1700, -1, "R4 max latency late");
    cyc(0,0,0,0, 0,0,0, 0,0,0,0, -1, "R10 quiet");
    chk("R3 expectations drained", 64'(expq.size()), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule